// File: doc/BRIEF.md
# Immediate-forming integer ALU

This block is the integer execute stage of a 32-bit load/store processor. It takes a 3-bit operation code and two register operands. The second operand can instead be formed from a 16-bit immediate. A half-select bit places that immediate in the upper or lower half of the word. The result is produced combinationally in the same cycle.

The block offers:
- addition and subtraction, each with or without the stored carry or borrow;
- three bitwise logic operations;
- a shift whose amount is signed, so a negative amount shifts right.

A small status register holds four condition flags: carry, overflow, zero and negative. The carry-consuming operations read the carry from this register. When flag update is enabled, the flags produced by the current operation are written on the next rising clock edge. When it is not enabled, the register keeps its value.

The register file, instruction fetch, branches and memory access are outside this block. A decoder drives the inputs directly from fields of an instruction word.

Top module: `imm_alu`

## Requirements
- R1: Operation code 000 gives A+B and 010 gives A-B, modulo 2^32.
- R2: Operation code 001 gives A+B+C and 011 gives A-B-C, where C is the stored carry flag (flags bit 0).
- R3: Operation codes 100, 101 and 110 give bitwise AND, OR and XOR of A and B.
- R4: With the immediate selected and the half bit clear, B is the immediate in bits 15:0 and zeros in bits 31:16. With the half bit set, B is the immediate in bits 31:16 and zeros in bits 15:0.
- R5: For AND (100) with an immediate, the half of B that the immediate does not cover is all ones.
- R6: Operation code 111 with an immediate shifts A by the immediate taken as a signed 16-bit amount. A positive amount shifts left. A negative amount shifts right by its magnitude. The half bit selects logical (0) or arithmetic (1) right shift.
- R7: Operation code 111 without an immediate takes the signed 32-bit amount from B. The 5-bit selector 10000 gives a logical right shift and 11000 gives an arithmetic right shift.
- R8: Flags layout: bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 negative. Carry is the carry-out for adds and the unsigned borrow for subtracts. Overflow is the signed overflow of adds and subtracts. Both carry and overflow are 0 for logic operations and shifts.
- R9: Zero is set when the result is all zeros, and negative equals result bit 31.
- R10: Flags are written on the rising clock edge only when flag update is high. Otherwise they keep their value.
- R11: An active-low reset clears all four flags.
- R12: A shift uses only the low 5 bits of the amount's magnitude. An amount of zero passes A through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| op_code | input | 3 | Operation select |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate value |
| use_imm | input | 1 | Form B from the immediate instead of opnd_b |
| imm_hi | input | 1 | Place the immediate in the upper half; for immediate shifts, select arithmetic |
| flag_en | input | 1 | Write the new flags at the next edge |
| shift_sel | input | 5 | Register-shift kind: 10000 logical, 11000 arithmetic |
| result | output | 32 | Operation result |
| flags | output | 4 | Stored flags {negative, zero, overflow, carry} |

## Verification
The only internal state is the flag register, and a wrong value there shows up at the ports in two ways. It is visible directly on `flags` one edge after the faulty update. It also changes `result` in the same cycle as the next carry-consuming add or subtract. The bench therefore interleaves flag-writing, flag-holding and carry-consuming operations, so that a corrupted or wrongly retained carry becomes visible immediately. Immediate placement and fill, and shift amounts of zero, ±31 and out-of-range values, are exercised directly because they leave no state behind.

// File: rtl/imm_alu.sv
module imm_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W/2-1:0] imm,
  input  logic         use_imm,
  input  logic         imm_hi,
  input  logic         flag_en,
  input  logic [4:0]   shift_sel,
  output logic [W-1:0] result,
  output logic [3:0]   flags
);
  localparam int HW = W / 2;
  localparam int SW = $clog2(W);

  logic [HW-1:0] fill;
  logic [W-1:0]  opnd2, amt, mag, shl, shr, shres;
  logic [W:0]    sum, dif;
  logic [SW-1:0] sh;
  logic          cin, arith, c_new, v_new;

  assign fill  = (op_code == 3'b100) ? {HW{1'b1}} : {HW{1'b0}};
  assign opnd2 = !use_imm ? opnd_b : (imm_hi ? {imm, fill} : {fill, imm});
  assign cin   = flags[0];

  assign sum = {1'b0, opnd_a} + {1'b0, opnd2} + {{W{1'b0}}, (op_code == 3'b001) & cin};
  assign dif = {1'b0, opnd_a} - {1'b0, opnd2} - {{W{1'b0}}, (op_code == 3'b011) & cin};

  assign amt   = use_imm ? {{HW{imm[HW-1]}}, imm} : opnd_b;
  assign arith = use_imm ? imm_hi : (shift_sel == 5'b11000);
  assign mag   = amt[W-1] ? (~amt + 1'b1) : amt;
  assign sh    = mag[SW-1:0];
  assign shl   = opnd_a << sh;
  assign shr   = arith ? W'($signed(opnd_a) >>> sh) : (opnd_a >> sh);
  assign shres = amt[W-1] ? shr : shl;

  always_comb begin
    result = '0;
    c_new  = 1'b0;
    v_new  = 1'b0;
    case (op_code)
      3'b000, 3'b001: begin
        result = sum[W-1:0];
        c_new  = sum[W];
        v_new  = (opnd_a[W-1] == opnd2[W-1]) && (result[W-1] != opnd_a[W-1]);
      end
      3'b010, 3'b011: begin
        result = dif[W-1:0];
        c_new  = dif[W];
        v_new  = (opnd_a[W-1] != opnd2[W-1]) && (result[W-1] != opnd_a[W-1]);
      end
      3'b100:  result = opnd_a & opnd2;
      3'b101:  result = opnd_a | opnd2;
      3'b110:  result = opnd_a ^ opnd2;
      default: result = shres;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags <= 4'b0000;
    else if (flag_en)
      flags <= {result[W-1], result == '0, v_new, c_new};
  end
endmodule

module imm_alu_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op_code,
  input logic [W-1:0] opnd_a,
  input logic         use_imm,
  input logic         imm_hi,
  input logic         flag_en,
  input logic [W-1:0] result,
  input logic [3:0]   flags
);
  assert_hold_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> $stable(flags));

  assert_logic_clears_cv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && op_code[2]) |=> (flags[1:0] == 2'b00));

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_en |=> (flags[2] == ($past(result) == '0)));

  assert_neg_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_en |=> (flags[3] == $past(result[W-1])));

  assert_and_ones_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'b100 && use_imm && !imm_hi) |-> (result[W-1:W/2] == opnd_a[W-1:W/2]));

  assert_or_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'b101 && use_imm && imm_hi) |-> (result[W/2-1:0] == opnd_a[W/2-1:0]));
endmodule

bind imm_alu imm_alu_checks #(.W(W)) u_checks (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a),
  .use_imm(use_imm), .imm_hi(imm_hi), .flag_en(flag_en),
  .result(result), .flags(flags)
);

// File: tb/imm_alu_bench.sv
module imm_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] imm = '0;
  logic        use_imm = 1'b0, imm_hi = 1'b0, flag_en = 1'b0;
  logic [4:0]  shift_sel = 5'b10000;
  logic [31:0] result;
  logic [3:0]  flags;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [3:0] model_flags = 4'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_alu u_imm_alu (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .imm(imm), .use_imm(use_imm), .imm_hi(imm_hi), .flag_en(flag_en),
    .shift_sel(shift_sel), .result(result), .flags(flags)
  );

  function automatic string req_of(input logic [2:0] op, input bit ui);
    if (op == 3'd7) return ui ? "R6" : "R7";
    if (op == 3'd4 && ui) return "R5";
    if (ui) return "R4";
    if (op == 3'd1 || op == 3'd3) return "R2";
    if (op >= 3'd4) return "R3";
    return "R1";
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input bit ui, input bit hi, input logic [4:0] sel,
                       input bit c_in, output logic [31:0] res, output bit c, output bit v);
    logic [15:0] fl;
    logic [31:0] bb;
    longint s, ss, amt, m;
    bit ar;
    fl = (op == 3'd4) ? 16'hFFFF : 16'h0000;
    bb = !ui ? b : (hi ? {im, fl} : {fl, im});
    c = 0; v = 0;
    case (op)
      3'd0, 3'd1: begin
        s  = longint'(a) + longint'(bb) + ((op == 3'd1) ? c_in : 0);
        ss = longint'($signed(a)) + longint'($signed(bb)) + ((op == 3'd1) ? c_in : 0);
        res = s[31:0]; c = s > 64'sd4294967295;
        v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      3'd2, 3'd3: begin
        s  = longint'(a) - longint'(bb) - ((op == 3'd3) ? c_in : 0);
        ss = longint'($signed(a)) - longint'($signed(bb)) - ((op == 3'd3) ? c_in : 0);
        res = s[31:0]; c = s < 0;
        v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      3'd4: res = a & bb;
      3'd5: res = a | bb;
      3'd6: res = a ^ bb;
      default: begin
        amt = ui ? longint'($signed(im)) : longint'($signed(b));
        ar  = ui ? hi : (sel == 5'b11000);
        if (amt >= 0) res = a << (amt % 32);
        else begin
          m = (-amt) % 32;
          res = ar ? 32'($signed(a) >>> m) : (a >> m);
        end
      end
    endcase
  endtask

  task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input bit ui, input bit hi, input bit fe,
                       input logic [4:0] sel, input string req);
    logic [31:0] er;
    bit ec, ev;
    op_code = op; opnd_a = a; opnd_b = b; imm = im; use_imm = ui; imm_hi = hi;
    flag_en = fe; shift_sel = sel;
    model(op, a, b, im, ui, hi, sel, model_flags[0], er, ec, ev);
    #(CLK_PERIOD/4);
    check(req, "result", result, er);
    @(posedge clk);
    if (fe) model_flags = {er[31], er == 32'd0, ev, ec};
    #1;
    check(fe ? "R8/R9" : "R10", "flags", {28'd0, flags}, {28'd0, model_flags});
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    opnd_a = 32'hFFFFFFFF; opnd_b = 32'h1; flag_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R11", "reset flags", {28'd0, flags}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 add carry out and overflow
    apply(3'd0, 32'hFFFFFFFF, 32'h1, 16'h0, 0, 0, 1, 5'b10000, "R1");
    apply(3'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0, 1, 5'b10000, "R1");
    // R2 carry consumed, flags held across a non-updating op (R10)
    apply(3'd0, 32'hFFFFFFFF, 32'h2, 16'h0, 0, 0, 1, 5'b10000, "R1");
    apply(3'd5, 32'h0, 32'h0, 16'h0, 0, 0, 0, 5'b10000, "R10");
    apply(3'd1, 32'h10, 32'h20, 16'h0, 0, 0, 1, 5'b10000, "R2");
    apply(3'd2, 32'h1, 32'h2, 16'h0, 0, 0, 1, 5'b10000, "R8");
    apply(3'd3, 32'h10, 32'h5, 16'h0, 0, 0, 1, 5'b10000, "R2");
    apply(3'd2, 32'h80000000, 32'h1, 16'h0, 0, 0, 1, 5'b10000, "R8");
    // R4 / R5 immediate placement
    apply(3'd5, 32'h0, 32'h0, 16'hABCD, 1, 0, 1, 5'b10000, "R4");
    apply(3'd5, 32'h0, 32'h0, 16'hABCD, 1, 1, 1, 5'b10000, "R4");
    apply(3'd4, 32'h12345678, 32'h0, 16'h0F0F, 1, 0, 1, 5'b10000, "R5");
    apply(3'd4, 32'h12345678, 32'h0, 16'h0F0F, 1, 1, 1, 5'b10000, "R5");
    apply(3'd0, 32'h1, 32'h0, 16'h0001, 1, 1, 1, 5'b10000, "R4");
    // R6 immediate shifts
    apply(3'd7, 32'h80000001, 32'h0, 16'd31, 1, 0, 1, 5'b10000, "R6");
    apply(3'd7, 32'h80000000, 32'h0, -16'sd31, 1, 0, 1, 5'b10000, "R6");
    apply(3'd7, 32'h80000000, 32'h0, -16'sd31, 1, 1, 1, 5'b10000, "R6");
    apply(3'd7, 32'hF0000000, 32'h0, -16'sd4, 1, 1, 1, 5'b10000, "R6");
    // R7 register shifts
    apply(3'd7, 32'hF0000000, -32'sd8, 16'h0, 0, 0, 1, 5'b10000, "R7");
    apply(3'd7, 32'hF0000000, -32'sd8, 16'h0, 0, 0, 1, 5'b11000, "R7");
    apply(3'd7, 32'h00000003, 32'd4, 16'h0, 0, 0, 1, 5'b11000, "R7");
    // R12 zero amount and magnitude wrap
    apply(3'd7, 32'hDEADBEEF, 32'd0, 16'h0, 0, 0, 1, 5'b10000, "R12");
    apply(3'd7, 32'hDEADBEEF, 32'h0, 16'h0, 1, 1, 1, 5'b10000, "R12");
    apply(3'd7, 32'hDEADBEEF, -32'sd33, 16'h0, 0, 0, 1, 5'b10000, "R12");
    apply(3'd7, 32'hDEADBEEF, 32'd40, 16'h0, 0, 0, 1, 5'b10000, "R12");
    apply(3'd6, 32'hAAAA5555, 32'hAAAA5555, 16'h0, 0, 0, 1, 5'b10000, "R9");
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      bit ui;
      op = 3'($urandom_range(0, 7));
      ui = ($urandom_range(0, 2) == 0);
      apply(op, $urandom, (i % 5 == 0) ? 32'($signed(6'($urandom))) : $urandom,
            16'($urandom), ui, 1'($urandom), ($urandom_range(0, 3) != 0),
            ($urandom_range(0, 1) == 0) ? 5'b10000 : 5'b11000, req_of(op, ui));
    end
    finish_run();
  end
endmodule